// File: doc/BRIEF.md
# Full-Bridge PWM Direction Steering

This block steers a single PWM waveform onto the four switch drives of a full bridge. In the forward direction, one high-side drive (`out_a`) is held on and the diagonally opposite low-side drive (`out_d`) is modulated. In the reverse direction, `out_c` is held on and `out_b` is modulated. The PWM waveform comes from a timer that sits outside the block. The block receives that timer's count, the period limit, the duty compare value and the prescale selection.

Software may flip the direction bit at any time. The block latches the request and applies it only at a period boundary. During the last prescaled timer tick of the period in which a change is pending, the two steady drives already swap to the new direction, and both modulated drives are forced off. The block inserts no dead band. It runs at the instruction rate, so one prescaled tick lasts 1, 4 or 16 clock cycles.

Top module: `fb_dir_steer`

## Requirements
- R1: With the active direction forward (0) and no change pending, `out_a` is 1, `out_c` and `out_b` are 0, and `out_d` follows the PWM.
- R2: With the active direction reverse (1) and no change pending, `out_c` is 1, `out_a` and `out_d` are 0, and `out_b` follows the PWM.
- R3: `dir_req` is registered every cycle. The active direction takes the registered value only at a period boundary. A boundary is the last clock cycle of the tick in which `tmr_cnt` equals `tmr_period`, so the new direction governs from the first cycle of the next period.
- R4: While a change is pending and `tmr_cnt` equals `tmr_period`, `out_a` and `out_c` already show the pending direction.
- R5: During that pre-switch window, `out_b` and `out_d` are both 0.
- R6: The pre-switch window lasts exactly one prescaled tick: 1 cycle for `psc_sel`=00, 4 cycles for 01, and 16 cycles for 10 or 11.
- R7: The PWM is 1 while `tmr_cnt < duty`. A duty of 0 gives a modulated drive that never turns on. A duty above the period gives a modulated drive that is on for the whole period.
- R8: While `rst_n` is low, all four drives are 0. Reset also sets both the active and the registered direction to forward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Instruction-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tmr_cnt | input | CNT_W | Count from the external PWM timer |
| tmr_period | input | CNT_W | Last count of a period (at least 1) |
| duty | input | CNT_W | Duty compare value |
| psc_sel | input | 2 | Timer prescale select: 00 = 1, 01 = 4, 1x = 16 |
| dir_req | input | 1 | Requested direction: 0 forward, 1 reverse |
| out_a | output | 1 | High-side drive, leg 1 (steady in forward) |
| out_b | output | 1 | Low-side drive, leg 1 (modulated in reverse) |
| out_c | output | 1 | High-side drive, leg 2 (steady in reverse) |
| out_d | output | 1 | Low-side drive, leg 2 (modulated in forward) |

## Verification
The bench builds the block with the default parameters: a 10-bit count and prescale lengths of 4 and 16. It runs every `psc_sel` code, including the redundant code 11, so all three window lengths occur and can be counted cycle by cycle. Periods are kept short (1 to 12 counts) so that hundreds of boundaries and direction changes happen in a short run. Duty values include zero, values inside the period and values above it. These cover the never-on and always-on modulation cases together with the forced-off window.

// File: rtl/fb_dir_steer.sv
module fb_dir_steer #(
  parameter int CNT_W   = 10,
  parameter int PSC_MID = 4,
  parameter int PSC_MAX = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] tmr_cnt,
  input  logic [CNT_W-1:0] tmr_period,
  input  logic [CNT_W-1:0] duty,
  input  logic [1:0]       psc_sel,
  input  logic             dir_req,
  output logic             out_a,
  output logic             out_b,
  output logic             out_c,
  output logic             out_d
);
  localparam int PH_W = $clog2(PSC_MAX) + 1;
  localparam logic [PH_W-1:0] PH_TOP = '1;

  logic [CNT_W-1:0] prev_cnt;
  logic [PH_W-1:0]  phase_q, phase_now, tick_len;
  logic             dir_pend, dir_act, run_q;
  logic             at_end, boundary, presw, eff_dir, pwm;

  always_comb begin
    case (psc_sel)
      2'b00:   tick_len = PH_W'(1);
      2'b01:   tick_len = PH_W'(PSC_MID);
      default: tick_len = PH_W'(PSC_MAX);
    endcase
  end

  // cycle index inside the current timer tick
  assign phase_now = (tmr_cnt != prev_cnt) ? '0 : phase_q;
  assign at_end    = tmr_cnt == tmr_period;
  assign boundary  = at_end && (phase_now == tick_len - PH_W'(1));
  assign presw     = at_end && (dir_pend != dir_act);
  assign eff_dir   = presw ? dir_pend : dir_act;
  assign pwm       = tmr_cnt < duty;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_cnt <= '0;
      phase_q  <= '0;
      dir_pend <= 1'b0;
      dir_act  <= 1'b0;
      run_q    <= 1'b0;
    end else begin
      prev_cnt <= tmr_cnt;
      phase_q  <= (phase_now == PH_TOP) ? phase_now : phase_now + PH_W'(1);
      dir_pend <= dir_req;
      run_q    <= 1'b1;
      if (boundary) dir_act <= dir_pend;
    end
  end

  assign out_a = run_q && !eff_dir;
  assign out_c = run_q && eff_dir;
  assign out_d = run_q && !presw && !dir_act && pwm;
  assign out_b = run_q && !presw && dir_act && pwm;
endmodule

module fb_dir_steer_chk #(
  parameter int CNT_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] tmr_cnt,
  input logic [CNT_W-1:0] tmr_period,
  input logic             dir_pend,
  input logic             dir_act,
  input logic             out_a,
  input logic             out_b,
  input logic             out_c,
  input logic             out_d
);
  assert_ac_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_a && out_c));
  assert_fwd_leg_R1: assert property (@(posedge clk) disable iff (!rst_n)
    out_d |-> (out_a && !out_b));
  assert_rev_leg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_b |-> (out_c && !out_d));
  assert_window_mod_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_cnt == tmr_period && dir_pend != dir_act) |-> (!out_b && !out_d));
  assert_dir_at_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_act != $past(dir_act)) |-> ($past(tmr_cnt) == $past(tmr_period)));

  always @(posedge clk)
    if (!rst_n)
      assert_reset_idle_R8: assert (!out_a && !out_b && !out_c && !out_d);
endmodule

bind fb_dir_steer fb_dir_steer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_period(tmr_period),
  .dir_pend(dir_pend), .dir_act(dir_act),
  .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d));

// File: tb/fb_dir_steer_tb.sv
module fb_dir_steer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 10;

  logic clk = 0, rst_n = 0;
  logic [CNT_W-1:0] tmr_cnt, tmr_period, duty;
  logic [1:0] psc_sel;
  logic dir_req;
  logic out_a, out_b, out_c, out_d;

  int checks = 0, errors = 0;
  int sub = 0, swcnt = 0;
  logic mpend = 0, mact = 0, mrun = 0, mact_seen = 0;

  fb_dir_steer #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .tmr_cnt(tmr_cnt), .tmr_period(tmr_period),
    .duty(duty), .psc_sel(psc_sel), .dir_req(dir_req),
    .out_a(out_a), .out_b(out_b), .out_c(out_c), .out_d(out_d));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int tlen(input logic [1:0] s);
    return (s == 2'b00) ? 1 : (s == 2'b01) ? 4 : 16;
  endfunction

  // bench timer and reference direction state
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sub <= 0; tmr_cnt <= '0; mpend <= 0; mact <= 0; mrun <= 0;
    end else begin
      mrun  <= 1;
      mpend <= dir_req;
      if (tmr_cnt == tmr_period && sub == tlen(psc_sel) - 1) mact <= mpend;
      if (sub == tlen(psc_sel) - 1) begin
        sub <= 0;
        tmr_cnt <= (tmr_cnt == tmr_period) ? '0 : tmr_cnt + 1'b1;
      end else sub <= sub + 1;
    end
  end

  task automatic chk(input string req, input string nm, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic check_cycle();
    logic presw, eff, pwm;
    string rac, rbd;
    presw = (tmr_cnt == tmr_period) && (mpend != mact);
    eff   = presw ? mpend : mact;
    pwm   = tmr_cnt < duty;
    if (!mrun || !rst_n) begin
      chk("R8", "a", out_a, 0); chk("R8", "b", out_b, 0);
      chk("R8", "c", out_c, 0); chk("R8", "d", out_d, 0);
      return;
    end
    if (presw) begin rac = "R4"; rbd = "R5"; end
    else if (mact != mact_seen) begin rac = "R3"; rbd = "R3"; end
    else begin
      rac = mact ? "R2" : "R1";
      rbd = (duty == 0 || duty > tmr_period) ? "R7" : rac;
    end
    mact_seen = mact;
    chk(rac, "a", out_a, !eff);
    chk(rac, "c", out_c, eff);
    chk(rbd, "d", out_d, !presw && !mact && pwm);
    chk(rbd, "b", out_b, !presw && mact && pwm);
    if (out_a !== !mact) swcnt++;
    if (tmr_cnt == tmr_period && sub == tlen(psc_sel) - 1) begin
      if (mpend != mact) begin
        checks++;
        if (swcnt != tlen(psc_sel)) begin
          errors++;
          $display("FAIL R6 window: actual %0d expected %0d", swcnt, tlen(psc_sel));
        end
      end
      swcnt = 0;
    end
  endtask

  task automatic segment(input logic [1:0] ps, input int mode);
    int n;
    rst_n = 0; dir_req = 0; psc_sel = ps; swcnt = 0; mact_seen = 0;
    tmr_period = CNT_W'($urandom_range(12, 1));
    duty = (mode == 0) ? '0 : (mode == 1) ? tmr_period + 1'b1 : CNT_W'($urandom_range(12, 0));
    repeat (2) @(negedge clk) check_cycle();
    rst_n = 1;
    n = (int'(tmr_period) + 1) * tlen(ps) * 10;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check_cycle();
      if (tmr_cnt != tmr_period && $urandom_range(2 * tlen(ps), 0) == 0) dir_req = ~dir_req;
      if (mode == 2 && $urandom_range(20, 0) == 0) duty = CNT_W'($urandom_range(13, 0));
    end
  endtask

  initial begin
    void'($urandom(32'd4242));
    tmr_period = 4; duty = 0; psc_sel = 0; dir_req = 0;
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 4; p++) segment(2'(p), m);
    for (int p = 0; p < 4; p++) segment(2'(p), 2);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule